// File: doc/BRIEF.md
# Round-Robin Prediction Stream Engine

This block turns predicted spatial access patterns into a stream of single-block read requests for the primary data cache. Each prediction arrives as a region base address, a bit vector marking the predicted blocks of that region, and the offset of the block that started the prediction. The trigger block is already being fetched by the demand access, so its bit is dropped on arrival. The rest of the vector is kept in one of several prediction registers until every bit has been sent.

All occupied registers drain at the same time. A round-robin arbiter picks which register issues on each accepted request. Within a register the pending blocks go out from the lowest index upward. A request carries the block's byte address, which is the region base plus the bit index times the block size. Requests leave over a valid/ready port and must be accepted before they are counted.

A counter tracks stream requests that have been accepted and not yet completed. While it sits at its limit, no request is offered. A new prediction that finds every register busy is discarded.

Top module: `stream_engine`

## Requirements
- R1: While reset is low, and on the first cycle after it, `req_valid` is 0. All registers are empty, the round-robin search starts at register 0, and the outstanding count is 0.
- R2: An accepted prediction goes into the lowest-indexed empty register, with bit `pred_trig_off` removed from `pred_pattern`. If the vector is empty after that removal, no register is taken and nothing is issued.
- R3: A prediction that arrives while every register holds pending bits is discarded. Its blocks are never requested.
- R4: Within a register, the lowest-indexed pending bit k is issued first. Its address is `base + k * 2**BLK_BITS` (64-byte blocks by default, so bit k adds k*64).
- R5: A pending bit is cleared only in the cycle its request is accepted (`req_valid && req_ready`). A register whose vector becomes empty is free again for the next prediction.
- R6: After a request from register i is accepted, the next grant goes to the first register at or after i+1, wrapping modulo NUM_SLOTS, that has pending bits.
- R7: While `req_valid` is 1 and `req_ready` is 0, `req_valid` stays 1 and `req_addr` stays unchanged in the next cycle, even if a new prediction is loaded.
- R8: The outstanding count rises by one per accepted request and falls by one per `req_done` pulse; both in one cycle leave it unchanged. `req_valid` is 0 while the count equals MAX_OUT (16 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_valid | input | 1 | A new prediction is present this cycle |
| pred_base | input | ADDR_W | Region base byte address of the prediction |
| pred_pattern | input | PAT_W | Predicted blocks of the region, bit k = block k |
| pred_trig_off | input | OFF_W | Block index of the trigger access within the region |
| req_valid | output | 1 | A block read request is offered |
| req_ready | input | 1 | The cache takes the offered request this cycle |
| req_addr | output | ADDR_W | Byte address of the offered block |
| req_done | input | 1 | One earlier stream request has completed |

## Verification
A single sparse pattern with its trigger bit inside the vector shows lowest-first ordering, the address arithmetic and the trigger removal. A pattern holding only the trigger bit shows that no register is taken. Two interleaved registers show the round-robin rotation, as opposed to draining one register at a time. A load made while a request is stalled, at the moment the pointer favours the new register, separates a held request from one that is re-arbitrated. Filling every register and then loading one more shows both the discard and the reuse of a drained register. A full 31-block pattern drives the counter to its limit and exercises a simultaneous completion and acceptance.

// File: rtl/stream_pkg.sv
// Package stream_pkg
// Shared defaults and small helpers for the prediction stream engine.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package stream_pkg;

    localparam int unsigned SE_SLOTS_DEF   = 4;   // prediction registers
    localparam int unsigned SE_ADDR_DEF    = 32;  // byte address width
    localparam int unsigned SE_PAT_DEF     = 32;  // blocks per region
    localparam int unsigned SE_BLK_DEF     = 6;   // log2 of block bytes
    localparam int unsigned SE_MAXOUT_DEF  = 16;  // outstanding stream limit

    // Index width for n items; never below one bit.
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Counter width able to hold the value n itself.
    function automatic int unsigned cnt_w(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/se_slot.sv
// Module se_slot
// One prediction register: region base plus pending-block vector.
// Offers the lowest pending block as a byte address and clears that
// block when told it was issued. It reports busy while any bit is pending.
// Assumes: load_en is only raised while the register is not busy, and
// issue is only raised while it is busy.
module se_slot #(
    parameter int unsigned ADDR_W = stream_pkg::SE_ADDR_DEF,
    parameter int unsigned PAT_W  = stream_pkg::SE_PAT_DEF,
    parameter int unsigned BLK_W  = stream_pkg::SE_BLK_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_base,
    input  logic [PAT_W-1:0]  load_vec,
    input  logic              issue,
    output logic              busy,
    output logic [ADDR_W-1:0] head_addr
);
    localparam int unsigned OFF_W = stream_pkg::idx_w(PAT_W);

    logic [PAT_W-1:0]  pend_q;
    logic [ADDR_W-1:0] base_q;
    logic [OFF_W-1:0]  head_idx;
    logic              head_found;

    // Priority encoder: index of the lowest pending block.
    always_comb begin
        head_idx   = '0;
        head_found = 1'b0;
        for (int i = 0; i < int'(PAT_W); i++) begin
            if (pend_q[i] && !head_found) begin
                head_idx   = OFF_W'(i);
                head_found = 1'b1;
            end
        end
    end

    // Register state: capture on load, drop the head bit on issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            base_q <= '0;
        end else if (load_en) begin
            pend_q <= load_vec;
            base_q <= load_base;
        end else if (issue) begin
            pend_q[head_idx] <= 1'b0;
        end
    end

    assign busy      = |pend_q;
    assign head_addr = base_q + (ADDR_W'(head_idx) << BLK_W);

    // The issued block must be gone from the vector one cycle later.
    AST_CLEAR_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !pend_q[$past(head_idx)]); // R5

    // A load never overwrites a register still holding blocks.
    AST_LOAD_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> !busy); // R3

    // Issue is only requested on a register that has something pending.
    AST_ISSUE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> busy); // R5

endmodule

// File: rtl/se_rr_arb.sv
// Module se_rr_arb
// Round-robin selector over N requesters. The search starts at the slot
// after the last accepted grant. While the consumer stalls an offered
// grant, that grant is held so the offer stays stable.
// Assumes: fire and stall are never both high; a held requester keeps
// requesting until it is accepted.
module se_rr_arb #(
    parameter int unsigned N = stream_pkg::SE_SLOTS_DEF
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N-1:0]                      req,
    input  logic                              fire,
    input  logic                              stall,
    output logic                              any,
    output logic [stream_pkg::idx_w(N)-1:0]   grant
);
    localparam int unsigned SLOT_W = stream_pkg::idx_w(N);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(N - 1);

    logic [SLOT_W-1:0] ptr_q;
    logic [SLOT_W-1:0] hold_idx_q;
    logic              hold_q;
    logic [SLOT_W-1:0] pick;

    // Rotating search from ptr_q, overridden by a held grant.
    always_comb begin
        int  cand;
        logic found;
        pick  = '0;
        found = 1'b0;
        for (int k = 0; k < int'(N); k++) begin
            cand = int'(ptr_q) + k;
            if (cand >= int'(N)) cand = cand - int'(N);
            if (!found && req[cand]) begin
                pick  = SLOT_W'(cand);
                found = 1'b1;
            end
        end
        if (hold_q && req[hold_idx_q]) pick = hold_idx_q;
    end

    // Pointer advance on acceptance, grant hold on stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q      <= '0;
            hold_q     <= 1'b0;
            hold_idx_q <= '0;
        end else if (fire) begin
            ptr_q  <= (pick == LAST) ? '0 : pick + 1'b1;
            hold_q <= 1'b0;
        end else if (stall) begin
            hold_q     <= 1'b1;
            hold_idx_q <= pick;
        end else begin
            hold_q <= 1'b0;
        end
    end

    assign any   = |req;
    assign grant = pick;

    // The selected slot is always one that is asking.
    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> req[grant]); // R6

    // A stalled grant is presented again in the next cycle.
    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> grant == $past(grant)); // R7

endmodule

// File: rtl/se_credit.sv
// Module se_credit
// Counts stream requests accepted but not completed, and reports whether
// another request may be offered.
// Assumes: dec only arrives for a request that was counted; a stray dec
// at zero is ignored.
module se_credit #(
    parameter int unsigned MAX_OUT = stream_pkg::SE_MAXOUT_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic room
);
    localparam int unsigned CNT_W = stream_pkg::cnt_w(MAX_OUT);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_OUT);

    logic [CNT_W-1:0] cnt_q;

    // Up on acceptance, down on completion, unchanged on both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign room = (cnt_q < LIMIT);

    // The count never passes the limit, so issue is gated in time.
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT); // R8

    // A lone acceptance raises the count by exactly one.
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec) |=> cnt_q == $past(cnt_q) + 1'b1); // R8

endmodule

// File: rtl/stream_engine.sv
// Module stream_engine
// Holds several predicted region patterns and streams their blocks as
// single read requests over a valid/ready port. Registers are drained
// in round-robin order, lowest block first within a register. Issue is
// limited by an outstanding-request budget.
// Assumes: pred_trig_off indexes a block inside the region; req_done
// pulses once per completed stream request.
module stream_engine #(
    parameter int unsigned NUM_SLOTS = stream_pkg::SE_SLOTS_DEF,
    parameter int unsigned ADDR_W    = stream_pkg::SE_ADDR_DEF,
    parameter int unsigned PAT_W     = stream_pkg::SE_PAT_DEF,
    parameter int unsigned BLK_W     = stream_pkg::SE_BLK_DEF,
    parameter int unsigned MAX_OUT   = stream_pkg::SE_MAXOUT_DEF,
    localparam int unsigned OFF_W    = stream_pkg::idx_w(PAT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_valid,
    input  logic [ADDR_W-1:0] pred_base,
    input  logic [PAT_W-1:0]  pred_pattern,
    input  logic [OFF_W-1:0]  pred_trig_off,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              req_done
);
    localparam int unsigned SLOT_W = stream_pkg::idx_w(NUM_SLOTS);

    logic [NUM_SLOTS-1:0] slot_busy;
    logic [NUM_SLOTS-1:0] slot_load;
    logic [NUM_SLOTS-1:0] slot_issue;
    logic [ADDR_W-1:0]    slot_addr [NUM_SLOTS];
    logic [PAT_W-1:0]     trimmed;
    logic [SLOT_W-1:0]    alloc_idx;
    logic                 alloc_ok;
    logic [SLOT_W-1:0]    grant;
    logic                 any_pend;
    logic                 room;
    logic                 fire;
    logic                 stall;

    // Remove the trigger block: the demand access already fetches it.
    always_comb begin
        trimmed = pred_pattern;
        trimmed[pred_trig_off] = 1'b0;
    end

    // Pick the lowest-indexed empty register for a new prediction.
    always_comb begin
        alloc_idx = '0;
        alloc_ok  = 1'b0;
        for (int i = 0; i < int'(NUM_SLOTS); i++) begin
            if (!slot_busy[i] && !alloc_ok) begin
                alloc_idx = SLOT_W'(i);
                alloc_ok  = 1'b1;
            end
        end
    end

    // Request handshake terms shared by arbiter, slots and budget.
    assign req_valid = any_pend && room;
    assign fire      = req_valid && req_ready;
    assign stall     = req_valid && !req_ready;
    assign req_addr  = slot_addr[grant];

    genvar g;
    generate
        for (g = 0; g < int'(NUM_SLOTS); g++) begin : g_slot
            // Per-register load and issue strobes.
            assign slot_load[g]  = pred_valid && alloc_ok && (|trimmed)
                                   && (alloc_idx == SLOT_W'(g));
            assign slot_issue[g] = fire && (grant == SLOT_W'(g));

            se_slot #(
                .ADDR_W (ADDR_W),
                .PAT_W  (PAT_W),
                .BLK_W  (BLK_W)
            ) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .load_en   (slot_load[g]),
                .load_base (pred_base),
                .load_vec  (trimmed),
                .issue     (slot_issue[g]),
                .busy      (slot_busy[g]),
                .head_addr (slot_addr[g])
            );
        end
    endgenerate

    se_rr_arb #(
        .N (NUM_SLOTS)
    ) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (slot_busy),
        .fire  (fire),
        .stall (stall),
        .any   (any_pend),
        .grant (grant)
    );

    se_credit #(
        .MAX_OUT (MAX_OUT)
    ) u_credit (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (fire),
        .dec   (req_done),
        .room  (room)
    );

    // Nothing is offered in the cycle after reset is applied.
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !req_valid); // R1

    // A stalled offer keeps its valid and address.
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> req_valid && $stable(req_addr)); // R7

    // At most one register is loaded and at most one issues per cycle.
    AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_load) && $onehot0(slot_issue)); // R2

endmodule

// File: tb/stream_engine_test.sv
// Directed bench for stream_engine: one task per scenario.
module stream_engine_test;
    localparam int unsigned AW = 32;
    localparam int unsigned PW = 32;
    localparam int unsigned OW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pred_valid;
    logic [AW-1:0] pred_base;
    logic [PW-1:0] pred_pattern;
    logic [OW-1:0] pred_trig_off;
    logic          req_valid;
    logic          req_ready;
    logic [AW-1:0] req_addr;
    logic          req_done;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    stream_engine uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pred_valid    (pred_valid),
        .pred_base     (pred_base),
        .pred_pattern  (pred_pattern),
        .pred_trig_off (pred_trig_off),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_done      (req_done)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic exp_req(input logic [31:0] addr, input string tag);
        chk(req_valid === 1'b1, {tag, " valid"}, 32'(req_valid), 32'd1);
        chk(req_addr === addr, {tag, " addr"}, req_addr, addr);
    endtask

    task automatic exp_idle(input string tag);
        chk(req_valid === 1'b0, tag, 32'(req_valid), 32'd0);
    endtask

    task automatic next_sample;
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0; pred_valid = 1'b0; pred_base = '0; pred_pattern = '0;
        pred_trig_off = '0; req_ready = 1'b0; req_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        exp_idle("R1 idle after reset");
    endtask

    task automatic load(input logic [31:0] base, input logic [31:0] pat,
                        input logic [4:0] trig);
        @(negedge clk);
        pred_valid = 1'b1; pred_base = base; pred_pattern = pat;
        pred_trig_off = trig;
        @(negedge clk);
        pred_valid = 1'b0;
        #1;
    endtask

    // Sparse pattern with trigger bit set; trigger-only pattern.
    task automatic t_single;
        do_reset();
        load(32'h1000, 32'hB4, 5'd4);          // pending 2,5,7
        exp_req(32'h1080, "R2 R4 first block, trigger removed");
        req_ready = 1'b1;
        next_sample(); exp_req(32'h1140, "R4 second block");
        next_sample(); exp_req(32'h11C0, "R4 third block");
        next_sample(); exp_idle("R5 register frees when empty");
        req_ready = 1'b0;
        load(32'h9000, 32'h8, 5'd3);
        exp_idle("R2 trigger-only pattern takes no register");
    endtask

    // Two registers interleave.
    task automatic t_round_robin;
        do_reset();
        load(32'h2000, 32'h3, 5'd5);
        load(32'h4000, 32'h48, 5'd0);
        exp_req(32'h2000, "R6 slot0 first after reset");
        req_ready = 1'b1;
        next_sample(); exp_req(32'h40C0, "R6 rotate to slot1");
        next_sample(); exp_req(32'h2040, "R6 back to slot0");
        next_sample(); exp_req(32'h4180, "R6 slot1 again");
        next_sample(); exp_idle("R5 both drained");
        req_ready = 1'b0;
    endtask

    // Load during a stall that would otherwise win arbitration.
    task automatic t_hold;
        do_reset();
        load(32'h3000, 32'h6, 5'd0);
        exp_req(32'h3040, "R4 lowest first");
        req_ready = 1'b1;
        next_sample(); exp_req(32'h3080, "R5 bit cleared on accept");
        req_ready = 1'b0;
        load(32'h5000, 32'h1, 5'd5);
        exp_req(32'h3080, "R7 stalled request held across load");
        next_sample(); exp_req(32'h3080, "R5 no clear without ready");
        req_ready = 1'b1;
        next_sample(); exp_req(32'h5000, "R6 slot1 after slot0");
        next_sample(); exp_idle("R5 all drained");
        req_ready = 1'b0;
    endtask

    // Fill every register, overflow one, then reuse a freed one.
    task automatic t_drop_reuse;
        do_reset();
        load(32'h10000, 32'h1, 5'd5);
        load(32'h20000, 32'h1, 5'd5);
        load(32'h30000, 32'h1, 5'd5);
        load(32'h40000, 32'h1, 5'd5);
        load(32'h0F000, 32'h1, 5'd5);          // must be discarded
        exp_req(32'h10000, "R2 lowest free slot0");
        req_ready = 1'b1;
        next_sample(); exp_req(32'h20000, "R2 slot1");
        next_sample(); exp_req(32'h30000, "R2 slot2");
        next_sample(); exp_req(32'h40000, "R2 slot3");
        next_sample(); exp_idle("R3 prediction dropped when full");
        req_ready = 1'b0;
        load(32'h50000, 32'h2, 5'd0);
        exp_req(32'h50040, "R5 freed register reused");
        req_ready = 1'b1;
        next_sample(); exp_idle("R5 drained");
        req_ready = 1'b0;
    endtask

    // Outstanding limit and simultaneous accept plus completion.
    task automatic t_credit;
        do_reset();
        load(32'h0, 32'hFFFF_FFFF, 5'd31);
        exp_req(32'h0, "R4 block 0");
        req_ready = 1'b1;
        for (int i = 1; i < 16; i++) begin
            next_sample();
            exp_req(32'(i * 64), "R4 R8 streaming below limit");
        end
        next_sample(); exp_idle("R8 blocked at 16 outstanding");
        req_ready = 1'b0; req_done = 1'b1;
        next_sample();
        req_done = 1'b0;
        exp_req(32'h400, "R8 completion reopens issue");
        req_ready = 1'b1; req_done = 1'b1;
        next_sample();
        req_done = 1'b0;
        exp_req(32'h440, "R8 accept plus done keeps count");
        next_sample(); exp_idle("R8 limit reached again");
        req_ready = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; pred_valid = 1'b0; pred_base = '0; pred_pattern = '0;
        pred_trig_off = '0; req_ready = 1'b0; req_done = 1'b0;
        t_single();
        t_round_robin();
        t_hold();
        t_drop_reuse();
        t_credit();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule